// File: doc/BRIEF.md
# Pipelined Multiply-Adder with Operand Shift Chain

This block takes several operand pairs at once, forms the product of each pair, and folds all the products into a single sum. Product 0 always enters the sum with a plus sign. Every later product has its own runtime bit that decides whether it is added or subtracted. A runtime sign bit decides whether all operands are read as two's complement or as unsigned values. Both control bits are captured in the same cycle as the operands. They then travel down the pipeline next to the data, so every result is formed with the controls that came with its own operands.

The pipeline is set by parameters. An input register and a product register can each be switched on or off. A result register is always present, and any number of extra delay stages can follow it. One clock enable and one synchronous clear act on every stage. A valid bit runs through the same stages as the data.

In shift-chain mode, only the A operand of pair 0 is taken from the ports. The registered A operand of each multiplier moves into the next multiplier on every enabled cycle, so the multipliers see a tapped delay line of A values. This is the usual structure of a direct-form FIR filter.

Top module: `mad_top`

## Requirements
- R1: `result` equals product 0, plus or minus each product k (k >= 1). Product k is subtracted when bit k-1 of `sub` is 1 and added when it is 0. The sum is taken modulo 2^RW.
- R2: When `sgn` is 1, both operands of every pair are read as W-bit two's complement values and the result is sign-extended. When `sgn` is 0, they are read as unsigned values.
- R3: RW = 2*W + clog2(NP). With every product added, the sum cannot overflow. This holds both when every operand is the most negative signed value and when every operand is the largest unsigned value.
- R4: A sample appears at `result` after L enabled cycles. L = IN_STAGE + PROD_REG + 1 + EXTRA, where IN_STAGE is 1 when IN_REG or CHAIN is set and 0 otherwise.
- R5: `sgn` and `sub` are captured together with their operands. Changing them in the cycle after a sample does not alter that sample's result.
- R6: When CHAIN is 1, multiplier 0 takes A from lane 0 of `a`. Multiplier k takes the A value that multiplier k-1 held before the last enabled edge. Lanes 1 to NP-1 of `a` have no effect on the result.
- R7: While `ce` is 0 and `sclr` is 0, every stage holds, so `result` and `out_valid` stay unchanged.
- R8: When `sclr` is 1 at a clock edge, every stage is cleared to zero, the shift chain included, whatever the value of `ce`.
- R9: `out_valid` is `in_valid` delayed by the same L enabled cycles as the data.
- R10: While `rst_n` is low, `result` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable for all stages |
| sclr | input | 1 | Synchronous clear for all stages |
| in_valid | input | 1 | Marks the operand sample as meaningful |
| sgn | input | 1 | 1 = signed operands, 0 = unsigned |
| sub | input | NP-1 | Bit k-1 = 1 subtracts product k |
| a | input | NP*W | A operands, pair k in bits k*W +: W |
| b | input | NP*W | B operands, pair k in bits k*W +: W |
| out_valid | output | 1 | Valid flag aligned with `result` |
| result | output | RW | Sum of signed or unsigned products |

## Verification
The bench runs two configurations side by side on the same stimulus. One has input, product, result and one extra stage, so each sample is due 4 enabled cycles later. The other is in shift-chain mode with only the input and result stages, so each sample is due 2 enabled cycles later. The reference model is a bench-side delay line per configuration that advances only when the bench drives `ce` high. It is emptied on the same edge on which `sclr` is driven. Outputs are compared at the falling edge against the last entry of that line. In this way stalls, clears and the shift-chain history are all counted in enabled cycles and not in wall-clock cycles.

// File: rtl/mad_pkg.sv
package mad_pkg;
    // Result width that holds NP full products without overflow
    function automatic int mad_res_w(input int w, input int np);
        return 2 * w + $clog2(np);
    endfunction
endpackage

// File: rtl/mad_in_stage.sv
module mad_in_stage #(
    parameter int W     = 8,
    parameter int NP    = 4,
    parameter int REG   = 1,
    parameter int CHAIN = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce,
    input  logic            sclr,
    input  logic [NP*W-1:0] a_i,
    input  logic [NP*W-1:0] b_i,
    input  logic            sgn_i,
    input  logic [NP-2:0]   sub_i,
    input  logic            vld_i,
    output logic [NP*W-1:0] a_o,
    output logic [NP*W-1:0] b_o,
    output logic            sgn_o,
    output logic [NP-2:0]   sub_o,
    output logic            vld_o
);
    localparam bit USE_REG = (REG != 0) || (CHAIN != 0);

    typedef struct packed {
        logic [NP*W-1:0] a;
        logic [NP*W-1:0] b;
        logic            sgn;
        logic [NP-2:0]   sub;
        logic            vld;
    } in_st_t;

    generate
        if (USE_REG) begin : g_reg
            in_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (sclr) begin
                    st_d = '0;
                end else if (ce) begin
                    if (CHAIN != 0) begin
                        // lane k takes the value lane k-1 held before this edge
                        st_d.a = {st_q.a[(NP-1)*W-1:0], a_i[W-1:0]};
                    end else begin
                        st_d.a = a_i;
                    end
                    st_d.b   = b_i;
                    st_d.sgn = sgn_i;
                    st_d.sub = sub_i;
                    st_d.vld = vld_i;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign a_o   = st_q.a;
            assign b_o   = st_q.b;
            assign sgn_o = st_q.sgn;
            assign sub_o = st_q.sub;
            assign vld_o = st_q.vld;
        end else begin : g_thru
            assign a_o   = a_i;
            assign b_o   = b_i;
            assign sgn_o = sgn_i;
            assign sub_o = sub_i;
            assign vld_o = vld_i;
        end
    endgenerate
endmodule

// File: rtl/mad_prod_stage.sv
module mad_prod_stage #(
    parameter int W   = 8,
    parameter int NP  = 4,
    parameter int RW  = 18,
    parameter int REG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             sclr,
    input  logic [NP*W-1:0]  a_i,
    input  logic [NP*W-1:0]  b_i,
    input  logic             sgn_i,
    input  logic [NP-2:0]    sub_i,
    input  logic             vld_i,
    output logic [NP*RW-1:0] prod_o,
    output logic [NP-2:0]    sub_o,
    output logic             vld_o
);
    typedef struct packed {
        logic [NP*RW-1:0] prod;
        logic [NP-2:0]    sub;
        logic             vld;
    } pr_st_t;

    logic [NP*RW-1:0] prod_c;

    // One (W+1)x(W+1) signed multiplier per pair; the extra top bit
    // is the operand's sign in signed mode and zero in unsigned mode.
    generate
        for (genvar k = 0; k < NP; k++) begin : g_mul
            logic signed [W:0]    ax, bx;
            logic signed [RW-1:0] pe;
            always_comb begin
                ax = {sgn_i & a_i[k*W+W-1], a_i[k*W +: W]};
                bx = {sgn_i & b_i[k*W+W-1], b_i[k*W +: W]};
                pe = RW'(ax) * RW'(bx);
            end
            assign prod_c[k*RW +: RW] = pe;
        end

        if (REG != 0) begin : g_reg
            pr_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (sclr) begin
                    st_d = '0;
                end else if (ce) begin
                    st_d.prod = prod_c;
                    st_d.sub  = sub_i;
                    st_d.vld  = vld_i;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign prod_o = st_q.prod;
            assign sub_o  = st_q.sub;
            assign vld_o  = st_q.vld;
        end else begin : g_thru
            assign prod_o = prod_c;
            assign sub_o  = sub_i;
            assign vld_o  = vld_i;
        end
    endgenerate
endmodule

// File: rtl/mad_sum_stage.sv
module mad_sum_stage #(
    parameter int NP    = 4,
    parameter int RW    = 18,
    parameter int EXTRA = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             sclr,
    input  logic [NP*RW-1:0] prod_i,
    input  logic [NP-2:0]    sub_i,
    input  logic             vld_i,
    output logic [RW-1:0]    res_o,
    output logic             vld_o
);
    localparam int NST = EXTRA + 1;

    typedef struct packed {
        logic [RW-1:0] res;
        logic          vld;
    } out_st_t;

    logic [RW-1:0]          sum_c;
    out_st_t [NST-1:0]      pipe_d, pipe_q;

    always_comb begin
        sum_c = prod_i[RW-1:0];
        for (int k = 1; k < NP; k++) begin
            if (sub_i[k-1]) sum_c = sum_c - prod_i[k*RW +: RW];
            else            sum_c = sum_c + prod_i[k*RW +: RW];
        end
    end

    always_comb begin
        pipe_d = pipe_q;
        if (sclr) begin
            pipe_d = '0;
        end else if (ce) begin
            pipe_d[0].res = sum_c;
            pipe_d[0].vld = vld_i;
            for (int s = 1; s < NST; s++) pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign res_o = pipe_q[NST-1].res;
    assign vld_o = pipe_q[NST-1].vld;
endmodule

// File: rtl/mad_top.sv
module mad_top #(
    parameter int W        = 8,
    parameter int NP       = 4,
    parameter int IN_REG   = 1,
    parameter int PROD_REG = 1,
    parameter int EXTRA    = 1,
    parameter int CHAIN    = 0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ce,
    input  logic                                sclr,
    input  logic                                in_valid,
    input  logic                                sgn,
    input  logic [NP-2:0]                       sub,
    input  logic [NP*W-1:0]                     a,
    input  logic [NP*W-1:0]                     b,
    output logic                                out_valid,
    output logic [mad_pkg::mad_res_w(W,NP)-1:0] result
);
    localparam int RW      = mad_pkg::mad_res_w(W, NP);
    localparam int IN_STG  = ((IN_REG != 0) || (CHAIN != 0)) ? 1 : 0;
    localparam int PR_STG  = (PROD_REG != 0) ? 1 : 0;
    localparam int LAT     = IN_STG + PR_STG + 1 + EXTRA;

    logic [NP*W-1:0]  s1_a, s1_b;
    logic             s1_sgn, s1_vld;
    logic [NP-2:0]    s1_sub;
    logic [NP*RW-1:0] s2_prod;
    logic [NP-2:0]    s2_sub;
    logic             s2_vld;

    mad_in_stage #(.W(W), .NP(NP), .REG(IN_REG), .CHAIN(CHAIN)) u_in (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr),
        .a_i(a), .b_i(b), .sgn_i(sgn), .sub_i(sub), .vld_i(in_valid),
        .a_o(s1_a), .b_o(s1_b), .sgn_o(s1_sgn), .sub_o(s1_sub), .vld_o(s1_vld)
    );

    mad_prod_stage #(.W(W), .NP(NP), .RW(RW), .REG(PROD_REG)) u_prod (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr),
        .a_i(s1_a), .b_i(s1_b), .sgn_i(s1_sgn), .sub_i(s1_sub), .vld_i(s1_vld),
        .prod_o(s2_prod), .sub_o(s2_sub), .vld_o(s2_vld)
    );

    mad_sum_stage #(.NP(NP), .RW(RW), .EXTRA(EXTRA)) u_sum (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr),
        .prod_i(s2_prod), .sub_i(s2_sub), .vld_i(s2_vld),
        .res_o(result), .vld_o(out_valid)
    );
endmodule

// File: rtl/mad_top_chk.sv
module mad_top_chk #(
    parameter int LAT = 4,
    parameter int RW  = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce,
    input logic          sclr,
    input logic          in_valid,
    input logic          out_valid,
    input logic [RW-1:0] result
);
    // valid shadow advanced by the port-level enable and clear
    logic [LAT-1:0] vshadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    vshadow <= '0;
        else if (sclr) vshadow <= '0;
        else if (ce)   vshadow <= (vshadow << 1) | LAT'(in_valid);
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) sclr |=> (!out_valid && result == '0)); // R8
    AST_STALL_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (!ce && !sclr) |=> $stable(result)); // R7
    AST_STALL_HOLDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (!ce && !sclr) |=> $stable(out_valid)); // R7
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n) out_valid == vshadow[LAT-1]); // R9
endmodule

bind mad_top mad_top_chk #(.LAT(LAT), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr),
    .in_valid(in_valid), .out_valid(out_valid), .result(result)
);

// File: tb/mad_top_bench.sv
module mad_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0, sclr = 1'b0, vld = 1'b0, sgn = 1'b0;
    logic [2:0]  sub = '0;
    logic [31:0] a = '0, b = '0;
    logic        ov0, ov1;
    logic [17:0] res0, res1;

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";
    bit done = 1'b0;

    // model state: [0] = registered pipeline, [1] = shift-chain
    logic [17:0] mres [0:1][0:7];
    logic        mvld [0:1][0:7];
    logic [7:0]  mareg[0:1][0:3];
    int          lat  [0:1] = '{4, 2};
    bit          chn  [0:1] = '{1'b0, 1'b1};

    always #10 clk = ~clk;

    mad_top #(.W(8), .NP(4), .IN_REG(1), .PROD_REG(1), .EXTRA(1), .CHAIN(0)) u_mad_top (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr), .in_valid(vld), .sgn(sgn),
        .sub(sub), .a(a), .b(b), .out_valid(ov0), .result(res0)
    );

    mad_top #(.W(8), .NP(4), .IN_REG(0), .PROD_REG(0), .EXTRA(0), .CHAIN(1)) u_mad_top_chain (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr), .in_valid(vld), .sgn(sgn),
        .sub(sub), .a(a), .b(b), .out_valid(ov1), .result(res1)
    );

    function automatic logic [17:0] calc(input logic [31:0] av, input logic [31:0] bv,
                                         input logic s, input logic [2:0] sb);
        int acc = 0;
        for (int k = 0; k < 4; k++) begin
            int x, y;
            x = s ? int'($signed(av[k*8 +: 8])) : int'({24'd0, av[k*8 +: 8]});
            y = s ? int'($signed(bv[k*8 +: 8])) : int'({24'd0, bv[k*8 +: 8]});
            if (k == 0 || !sb[k-1]) acc = acc + x * y;
            else                    acc = acc - x * y;
        end
        return acc[17:0];
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_outs();
        chk(cur_req, "result main", int'(res0), int'(mres[0][lat[0]-1]));
        chk(cur_req, "result chain", int'(res1), int'(mres[1][lat[1]-1]));
        chk("R9", "valid main", int'(ov0), int'(mvld[0][lat[0]-1]));
        chk("R9", "valid chain", int'(ov1), int'(mvld[1][lat[1]-1]));
    endtask

    task automatic model_clear();
        for (int i = 0; i < 2; i++) begin
            for (int j = 0; j < 8; j++) begin mres[i][j] = '0; mvld[i][j] = 1'b0; end
            for (int k = 0; k < 4; k++) mareg[i][k] = '0;
        end
    endtask

    task automatic cycle(input logic [31:0] ia, input logic [31:0] ib, input logic isg,
                         input logic [2:0] isb, input logic iv, input logic ice, input logic iclr);
        @(negedge clk);
        check_outs();
        a = ia; b = ib; sgn = isg; sub = isb; vld = iv; ce = ice; sclr = iclr;
        if (iclr) begin
            model_clear();
        end else if (ice) begin
            for (int i = 0; i < 2; i++) begin
                logic [31:0] av;
                for (int j = 7; j > 0; j--) begin
                    mres[i][j] = mres[i][j-1]; mvld[i][j] = mvld[i][j-1];
                end
                if (chn[i]) begin
                    for (int k = 3; k > 0; k--) mareg[i][k] = mareg[i][k-1];
                    mareg[i][0] = ia[7:0];
                end else begin
                    for (int k = 0; k < 4; k++) mareg[i][k] = ia[k*8 +: 8];
                end
                for (int k = 0; k < 4; k++) av[k*8 +: 8] = mareg[i][k];
                mres[i][0] = calc(av, ib, isg, isb);
                mvld[i][0] = iv;
            end
        end
    endtask

    task automatic rnd(input int n, input int sg_mode, input int ce_pct);
        for (int t = 0; t < n; t++) begin
            logic s;
            s = (sg_mode == 2) ? logic'($urandom_range(0, 1)) : logic'(sg_mode);
            cycle($urandom, $urandom, s, 3'($urandom), logic'($urandom_range(0, 1)),
                  ($urandom_range(0, 99) < ce_pct), 1'b0);
        end
    endtask

    task automatic flush(input int n);
        for (int t = 0; t < n; t++) cycle('0, '0, 1'b0, 3'b0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        #5;
        // R10: outputs quiet while reset is low
        chk("R10", "reset result main", int'(res0), 0);
        chk("R10", "reset valid main", int'(ov0), 0);
        chk("R10", "reset result chain", int'(res1), 0);
        chk("R10", "reset valid chain", int'(ov1), 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: most negative signed and largest unsigned, all added
        cur_req = "R3";
        cycle(32'h80808080, 32'h80808080, 1'b1, 3'b000, 1'b1, 1'b1, 1'b0);
        cycle(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 3'b000, 1'b1, 1'b1, 1'b0);
        cycle(32'h80808080, 32'h7F7F7F7F, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0);
        flush(6);

        // R4: isolated pulse, checked in the exact due cycle
        cur_req = "R4";
        cycle(32'h03020105, 32'h01010107, 1'b0, 3'b010, 1'b1, 1'b1, 1'b0);
        flush(6);

        // R1: add/subtract mixes; R2: signed and unsigned reading
        cur_req = "R1";
        rnd(60, 2, 100);
        cur_req = "R2";
        rnd(40, 1, 100);
        rnd(40, 0, 100);

        // R5: controls toggle every cycle, back-to-back samples
        cur_req = "R5";
        for (int t = 0; t < 40; t++)
            cycle($urandom, $urandom, logic'(t % 2), 3'(t), 1'b1, 1'b1, 1'b0);

        // R7: random stalls
        cur_req = "R7";
        rnd(80, 2, 50);

        // R8: clear with ce low, then with ce high
        cur_req = "R8";
        rnd(10, 2, 100);
        cycle($urandom, $urandom, 1'b1, 3'b101, 1'b1, 1'b0, 1'b1);
        cycle('0, '0, 1'b0, 3'b0, 1'b0, 1'b0, 1'b0);
        chk("R8", "cleared result main", int'(res0), 0);
        chk("R8", "cleared result chain", int'(res1), 0);
        rnd(10, 2, 100);
        cycle($urandom, $urandom, 1'b0, 3'b000, 1'b1, 1'b1, 1'b1);
        flush(6);

        // R6: upper A lanes carry noise; the chain must ignore them
        cur_req = "R6";
        rnd(60, 2, 80);
        flush(6);

        cycle('0, '0, 1'b0, 3'b0, 1'b0, 1'b1, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule